// File: doc/BRIEF.md
# Flash Page Programming Controller

This block sits between a processor's register port and a behavioural non-volatile array. Software first maps a 128-byte page buffer, fills any subset of it through a byte-wide buffer-write port, and then launches a program operation. The operation targets one of three spaces: the main user array, a single extra row, or a one-byte security location. A launch requires a two-step key written into the upper nibble of an 8-bit control register. The key nibble must be 5h on one control write and Ah on the control write that follows.

Once launched, the controller walks the buffer twice. In the first pass it issues an erase strobe for every loaded location. In the second pass it issues a masked write strobe for every loaded location. It then waits a fixed number of cycles, set by a parameter, that stands for the programming time. A busy bit in the control register and a processor-stall output stay high for the whole operation and are cleared only by hardware. When the operation completes, the record of loaded bytes is cleared, so the next operation starts from an empty buffer.

Top module: `flash_page_prog`

## Requirements
- R1: After reset the control register reads 00h, `cpu_stall_o` is low, and no erase or write strobe is issued.
- R2: The control register holds the key nibble in bits 7:4, the buffer-map enable in bit 3, the space select in bits 2:1 and busy in bit 0. Bits 7:1 read back as last written. Software writes to bit 0 have no effect.
- R3: An operation starts only when a control write carrying key 5h is followed directly by a control write carrying key Ah. Any other control write in between returns the sequence to idle, and any other order starts nothing.
- R4: The space select of the launching write picks the target: 00 is the user array, 01 is the extra row, 10 is the security byte. With 11 the launch does nothing and busy stays low.
- R5: A buffer write is accepted only while the map enable bit is 1 and busy is 0. Address bits 6:0 select the byte, and bits 14:7 of the most recent accepted write select the target page.
- R6: Only loaded bytes are touched. All erase strobes of an operation come before its first write strobe. User-array addresses are {page, byte}. Extra-row addresses are {0, byte}. Bytes that were not loaded get no strobe.
- R7: For the security space, only buffer byte 0 is used, at address 0. The write mask is F0h, so the lower nibble of that byte is never changed.
- R8: Busy and `cpu_stall_o` go high in the cycle after the launching write. They stay high for exactly 2*128 + PROG_CYCLES cycles and then drop on their own.
- R9: Control writes and buffer writes made while busy is high are ignored.
- R10: The loaded-byte record is cleared when an operation completes. A relaunch with nothing reloaded issues no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read value, including busy |
| buf_we_i | input | 1 | Page buffer write strobe |
| buf_addr_i | input | PAGE_W+OFS_W | Buffer address: page bits above byte offset |
| buf_wdata_i | input | DATA_W | Buffer write data |
| mem_erase_o | output | 1 | Erase strobe toward the array |
| mem_we_o | output | 1 | Write strobe toward the array |
| mem_space_o | output | 2 | Target space of the current strobe |
| mem_addr_o | output | PAGE_W+OFS_W | Array address of the current strobe |
| mem_wdata_o | output | DATA_W | Data for the write strobe |
| mem_mask_o | output | DATA_W | Per-bit write/erase enable |
| cpu_stall_o | output | 1 | Holds the processor idle while programming |

## Verification
The bench keeps the full 128-byte page and 8-bit page field, so the wrap of the byte counter at offset 127 is part of every pass. It lowers PROG_CYCLES to 20. With that value each operation takes 276 busy cycles, and dozens of launches, including those started while busy, fit in a short run. The busy window is counted against the exact expected length. Strobe addresses, data and masks are compared for all three spaces, with pages switched between buffer writes.

// File: rtl/flash_prog_pkg.sv
`timescale 1ns/1ps
package flash_prog_pkg;
  typedef enum logic [1:0] {
    SPACE_USER = 2'b00,
    SPACE_XROW = 2'b01,
    SPACE_SEC  = 2'b10,
    SPACE_NONE = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ERASE,
    SEQ_PROG,
    SEQ_WAIT
  } seq_e;

  localparam logic [3:0] KEY_FIRST  = 4'h5;
  localparam logic [3:0] KEY_SECOND = 4'hA;
endpackage

// File: rtl/flash_unlock.sv
`timescale 1ns/1ps
module flash_unlock
  import flash_prog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] key_i,
  input  logic [1:0] space_i,
  output logic       launch_o
);
  logic armed_q;

  assign launch_o = wr_i && armed_q && (key_i == KEY_SECOND) &&
                    (space_i != SPACE_NONE);

  // every accepted control write re-evaluates the arm state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (key_i == KEY_FIRST);
  end
endmodule

// File: rtl/flash_page_buf.sv
`timescale 1ns/1ps
module flash_page_buf #(
  parameter int OFS_W  = 7,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [PAGE_W+OFS_W-1:0] addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    clr_i,
  input  logic [OFS_W-1:0]        rd_ofs_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    rd_loaded_o,
  output logic [PAGE_W-1:0]       page_o
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  loaded_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  wr_ofs;

  assign wr_ofs = addr_i[OFS_W-1:0];

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[wr_ofs] <= wdata_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            loaded_q[g] <= 1'b0;
      else if (clr_i)                         loaded_q[g] <= 1'b0;
      else if (we_i && wr_ofs == OFS_W'(g))   loaded_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= '0;
    else if (we_i) page_q <= addr_i[PAGE_W+OFS_W-1:OFS_W];
  end

  assign rd_data_o   = data_q[rd_ofs_i];
  assign rd_loaded_o = loaded_q[rd_ofs_i];
  assign page_o      = page_q;
endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int OFS_W       = 7,
  parameter int PAGE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    launch_i,
  input  logic [1:0]              space_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  input  logic                    rd_loaded_i,
  output logic [OFS_W-1:0]        rd_ofs_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    mem_erase_o,
  output logic                    mem_we_o,
  output logic [1:0]              mem_space_o,
  output logic [PAGE_W+OFS_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic [DATA_W-1:0]       mem_mask_o
);
  localparam int               CNT_W    = $clog2(PROG_CYCLES + 1);
  localparam int               RO_BITS  = DATA_W / 2;
  localparam logic [OFS_W-1:0] OFS_LAST = '1;

  seq_e             state_q;
  space_e           space_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             elig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      space_q <= SPACE_USER;
      ofs_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (launch_i) begin
          state_q <= SEQ_ERASE;
          ofs_q   <= '0;
          space_q <= space_e'(space_i);
        end
        SEQ_ERASE: begin
          ofs_q <= ofs_q + 1'b1;
          if (ofs_q == OFS_LAST) state_q <= SEQ_PROG;
        end
        SEQ_PROG: begin
          ofs_q <= ofs_q + 1'b1;
          if (ofs_q == OFS_LAST) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= CNT_W'(PROG_CYCLES - 1);
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == '0) state_q <= SEQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // security space uses buffer byte 0 only
  assign elig = rd_loaded_i && ((space_q != SPACE_SEC) || (ofs_q == '0));

  always_comb begin
    unique case (space_q)
      SPACE_USER: mem_addr_o = {page_i, ofs_q};
      SPACE_XROW: mem_addr_o = {{PAGE_W{1'b0}}, ofs_q};
      default:    mem_addr_o = '0;
    endcase
  end

  assign mem_mask_o  = (space_q == SPACE_SEC) ?
                       {{(DATA_W-RO_BITS){1'b1}}, {RO_BITS{1'b0}}} : '1;
  assign mem_erase_o = (state_q == SEQ_ERASE) && elig;
  assign mem_we_o    = (state_q == SEQ_PROG) && elig;
  assign mem_wdata_o = rd_data_i;
  assign mem_space_o = space_q;
  assign rd_ofs_o    = ofs_q;
  assign busy_o      = (state_q != SEQ_IDLE);
  assign done_o      = (state_q == SEQ_WAIT) && (cnt_q == '0);
endmodule

// File: rtl/flash_page_prog.sv
`timescale 1ns/1ps
module flash_page_prog #(
  parameter int OFS_W       = 7,
  parameter int PAGE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctl_we_i,
  input  logic [7:0]              ctl_wdata_i,
  output logic [7:0]              ctl_rdata_o,
  input  logic                    buf_we_i,
  input  logic [PAGE_W+OFS_W-1:0] buf_addr_i,
  input  logic [DATA_W-1:0]       buf_wdata_i,
  output logic                    mem_erase_o,
  output logic                    mem_we_o,
  output logic [1:0]              mem_space_o,
  output logic [PAGE_W+OFS_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic [DATA_W-1:0]       mem_mask_o,
  output logic                    cpu_stall_o
);
  logic [3:0]        key_q;
  logic              map_q;
  logic [1:0]        space_q;
  logic              busy, done, launch, ctl_wr, buf_wr;
  logic [OFS_W-1:0]  rd_ofs;
  logic [DATA_W-1:0] rd_data;
  logic              rd_loaded;
  logic [PAGE_W-1:0] page;

  assign ctl_wr = ctl_we_i && !busy;
  assign buf_wr = buf_we_i && map_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      map_q   <= 1'b0;
      space_q <= '0;
    end else if (ctl_wr) begin
      key_q   <= ctl_wdata_i[7:4];
      map_q   <= ctl_wdata_i[3];
      space_q <= ctl_wdata_i[2:1];
    end
  end

  assign ctl_rdata_o = {key_q, map_q, space_q, busy};
  assign cpu_stall_o = busy;

  flash_unlock u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctl_wr),
    .key_i    (ctl_wdata_i[7:4]),
    .space_i  (ctl_wdata_i[2:1]),
    .launch_o (launch)
  );

  flash_page_buf #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (buf_wr),
    .addr_i      (buf_addr_i),
    .wdata_i     (buf_wdata_i),
    .clr_i       (done),
    .rd_ofs_i    (rd_ofs),
    .rd_data_o   (rd_data),
    .rd_loaded_o (rd_loaded),
    .page_o      (page)
  );

  flash_prog_seq #(.OFS_W(OFS_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                   .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .space_i     (ctl_wdata_i[2:1]),
    .page_i      (page),
    .rd_data_i   (rd_data),
    .rd_loaded_i (rd_loaded),
    .rd_ofs_o    (rd_ofs),
    .busy_o      (busy),
    .done_o      (done),
    .mem_erase_o (mem_erase_o),
    .mem_we_o    (mem_we_o),
    .mem_space_o (mem_space_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_mask_o  (mem_mask_o)
  );
endmodule

// File: rtl/flash_page_prog_chk.sv
`timescale 1ns/1ps
module flash_page_prog_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_we_i,
  input logic [7:0]        ctl_wdata_i,
  input logic [7:0]        ctl_rdata_o,
  input logic              mem_erase_o,
  input logic              mem_we_o,
  input logic [1:0]        mem_space_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_mask_o,
  input logic              cpu_stall_o
);
  localparam logic [DATA_W-1:0] SEC_MASK = {{(DATA_W-DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};

  p_stall_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o == ctl_rdata_o[0]);

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[0] |-> !mem_we_o && !mem_erase_o);

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_erase_o));

  p_sec_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_space_o == 2'b10) |-> (mem_addr_o == '0 && mem_mask_o == SEC_MASK));

  p_launch_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_rdata_o[0]) |-> ($past(ctl_we_i) && $past(ctl_wdata_i[7:4]) == 4'hA &&
                               $past(ctl_wdata_i[2:1]) != 2'b11));

  p_ctl_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[0] && ctl_we_i) |=> ctl_rdata_o[7:1] == $past(ctl_rdata_o[7:1]));

  p_space_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[0] && $past(ctl_rdata_o[0])) |-> $stable(mem_space_o));
endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_W(PAGE_W + OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .mem_erase_o (mem_erase_o),
  .mem_we_o    (mem_we_o),
  .mem_space_o (mem_space_o),
  .mem_addr_o  (mem_addr_o),
  .mem_mask_o  (mem_mask_o),
  .cpu_stall_o (cpu_stall_o)
);

// File: tb/flash_page_prog_test.sv
`timescale 1ns/1ps
module flash_page_prog_test;
  localparam int PROG = 20;
  localparam int BUSY_LEN = 256 + PROG;
  localparam int LOGN = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        buf_we = 1'b0;
  logic [14:0] buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic        mem_erase, mem_we, stall;
  logic [1:0]  mem_space;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_mask;

  int n_chk = 0, n_fail = 0;
  int wr_tot = 0, er_tot = 0, cyc = 0;
  logic [14:0] lg_addr [LOGN];
  logic [7:0]  lg_data [LOGN];
  logic [7:0]  lg_mask [LOGN];
  logic [1:0]  lg_sp   [LOGN];
  int          lg_er   [LOGN];

  // {key1, key2, space[1:0], kind[1:0] (0 none,1 user,2 xrow,3 sec), writes[3:0]}
  localparam logic [15:0] VEC [8] = '{16'h5A13, 16'hA500, 16'h5500, 16'h5AC0,
                                      16'h5A63, 16'h3A00, 16'h5AB1, 16'h5A13};

  flash_page_prog #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata),
    .mem_erase_o(mem_erase), .mem_we_o(mem_we), .mem_space_o(mem_space),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_mask_o(mem_mask),
    .cpu_stall_o(stall)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_erase) er_tot++;
      if (mem_we) begin
        if (wr_tot < LOGN) begin
          lg_addr[wr_tot] = mem_addr;
          lg_data[wr_tot] = mem_wdata;
          lg_mask[wr_tot] = mem_mask;
          lg_sp[wr_tot]   = mem_space;
          lg_er[wr_tot]   = er_tot;
        end
        wr_tot++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic buf_wr(input logic [7:0] pg, input logic [6:0] ofs, input logic [7:0] d);
    @(negedge clk); buf_we = 1'b1; buf_addr = {pg, ofs}; buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (ctl_rdata[0]) @(negedge clk);
  endtask

  function automatic logic [7:0] dat(input int i, input int ofs);
    return 8'((i << 4) | (ofs & 15));
  endfunction

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wr0, er0, t0;
    logic [15:0] e;
    int kind, nexp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 8'h00, "R1 ctl reset", ctl_rdata, 0);
    chk(!stall && !mem_we && !mem_erase, "R1 idle outputs", {stall, mem_we, mem_erase}, 0);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 8; i++) begin
      e = VEC[i]; kind = int'(e[5:4]); nexp = int'(e[3:0]);
      wr0 = wr_tot; er0 = er_tot;
      ctl_wr(8'h08);
      buf_wr(8'd5, 7'd0,   dat(i, 0));
      buf_wr(8'd5, 7'd3,   dat(i, 3));
      buf_wr(8'd9, 7'd127, dat(i, 127));
      ctl_wr({e[15:12], 1'b1, e[7:6], 1'b0});
      ctl_wr({e[11:8],  1'b1, e[7:6], 1'b0});
      chk(ctl_rdata[0] == (kind != 0), "R3 launch decision", ctl_rdata[0], kind != 0);
      wait_idle();
      chk(wr_tot - wr0 == nexp, "R4 write count", wr_tot - wr0, nexp);
      chk(er_tot - er0 == nexp, "R6 erase count", er_tot - er0, nexp);
      for (int k = 0; k < nexp; k++) begin
        int ofs;
        logic [14:0] ea;
        ofs = (kind == 3) ? 0 : ((k == 0) ? 0 : (k == 1) ? 3 : 127);
        ea  = (kind == 1) ? {8'd9, 7'(ofs)} : (kind == 2) ? {8'd0, 7'(ofs)} : 15'd0;
        chk(lg_addr[wr0+k] == ea, "R5 R6 address", lg_addr[wr0+k], ea);
        chk(lg_data[wr0+k] == dat(i, ofs), "R6 data", lg_data[wr0+k], dat(i, ofs));
        chk(lg_mask[wr0+k] == ((kind == 3) ? 8'hF0 : 8'hFF), "R7 mask",
            lg_mask[wr0+k], (kind == 3) ? 8'hF0 : 8'hFF);
        chk(lg_sp[wr0+k] == 2'(kind - 1), "R4 space", lg_sp[wr0+k], kind - 1);
        chk(lg_er[wr0+k] - er0 == nexp, "R6 erase before write", lg_er[wr0+k] - er0, nexp);
      end
    end

    // R8 R9: busy window, writes during busy
    wr0 = wr_tot;
    ctl_wr(8'h08);
    buf_wr(8'd2, 7'd5, 8'hC5);
    ctl_wr(8'h58);
    ctl_wr(8'hA8);
    t0 = cyc;
    ctl_wr(8'hF6);
    buf_wr(8'd3, 7'd6, 8'h66);
    chk(stall == 1'b1, "R8 stall during busy", stall, 1);
    wait_idle();
    chk(cyc - t0 == BUSY_LEN, "R8 busy length", cyc - t0, BUSY_LEN);
    chk(stall == 1'b0, "R8 stall released", stall, 0);
    chk(ctl_rdata == 8'hA8, "R9 ctl write ignored", ctl_rdata, 8'hA8);
    chk(wr_tot - wr0 == 1 && lg_addr[wr0] == {8'd2, 7'd5}, "R9 single write",
        lg_addr[wr0], {8'd2, 7'd5});
    wr0 = wr_tot;
    ctl_wr(8'h08); ctl_wr(8'h58); ctl_wr(8'hA8);
    wait_idle();
    chk(wr_tot - wr0 == 0, "R10 R9 flags cleared, busy buffer write dropped", wr_tot - wr0, 0);

    // R2 field readback, busy bit not writable
    ctl_wr(8'h09);
    chk(ctl_rdata == 8'h08, "R2 busy bit write ignored", ctl_rdata, 8'h08);
    ctl_wr(8'h36);
    chk(ctl_rdata == 8'h36, "R2 field readback", ctl_rdata, 8'h36);

    // R5 buffer write with map disabled
    wr0 = wr_tot;
    ctl_wr(8'h00);
    buf_wr(8'd4, 7'd1, 8'h41);
    ctl_wr(8'h58); ctl_wr(8'hA8);
    chk(ctl_rdata[0] == 1'b1, "R5 launch accepted", ctl_rdata[0], 1);
    wait_idle();
    chk(wr_tot - wr0 == 0, "R5 unmapped write ignored", wr_tot - wr0, 0);

    // R3 interrupted key sequence
    wr0 = wr_tot;
    ctl_wr(8'h08);
    buf_wr(8'd1, 7'd2, 8'h77);
    ctl_wr(8'h58); ctl_wr(8'h08); ctl_wr(8'hA8);
    chk(ctl_rdata[0] == 1'b0, "R3 interrupted sequence", ctl_rdata[0], 0);
    ctl_wr(8'h58); ctl_wr(8'hA8);
    wait_idle();
    chk(wr_tot - wr0 == 1 && lg_addr[wr0] == {8'd1, 7'd2} && lg_data[wr0] == 8'h77,
        "R3 retried launch", lg_data[wr0], 8'h77);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule